// File: doc/BRIEF.md
# Character-Cell Pixel Serializer with Colour Attributes

This block turns display bytes into a stream of 3-bit RGB pixels, one per clock, at one bit per pixel. Each byte covers one character column of 8 pixels, most significant bit first. Each pixel can be held for 1, 2, 3 or 4 clocks, so that an active window of 640 clocks carries 80, 40, 26 or 20 columns. The block issues its own memory reads for the bitmap bytes, one per character column, and tags each read as bitmap or attribute. Each read returns its byte one clock later.

In the scaled modes, the slot halfway through each column period would otherwise be idle. When attributes are enabled, the block uses that slot to read a colour attribute byte for the same column. Attribute reads happen only on the first pixel row of a character row (row index 0). The bytes go into a 40-entry line buffer and are reused on the next seven rows. An attribute has to arrive before the pixels it colours, so the first column period of the line is output black. Column k then appears one period later than in the plain modes, and the line loses one column. A half-rate option reads one attribute for each pair of columns and splits it into two nibbles, one for each column. Each nibble picks a 2-bit foreground code and a 2-bit background code from a fixed four-colour map.

Top module: `attr_pixel_serializer`

## Requirements
- R1: While reset is held and on the first cycle after it, `rgb` is 000 and `mem_rd` is 0.
- R2: Counting line slots from 0 at the first clock with `line_act` high, let S be the scale (`cfg_scale` 0,1,2,3 gives S = 1,2,3,4) and P = 8·S. The block issues a bitmap read (`mem_is_attr` = 0, `mem_col` = k) at slot k·P, for k from 0 to F−1. F is 640/P rounded down, minus one when attributes are in effect. A bitmap read is never followed by a read on the next clock.
- R3: Without attributes, slot s shows bit 7−((s mod P)/S) of the byte for column s/P. A set bit gives `rgb` 111 and a clear bit gives 000. The pixel for slot s appears on `rgb` three clocks after slot s.
- R4: At scale code 2 (x3), 26 columns fill slots 0–623 (25 columns with attributes), and the remaining 16 slots of the line are black.
- R5: `rgb` is 000 for any slot where `line_act` was low.
- R6: With attributes in effect on row index 0, an attribute read (`mem_is_attr` = 1) for column k is issued at slot k·P + 4·S. It comes after the bitmap read for the same column.
- R7: On row indexes 1–7, no attribute read is issued. The attribute bytes stored on the last row 0 are used instead, even if memory now holds other values.
- R8: With attributes in effect, slots 0 to P−1 are black, and column k is shown during period k+1.
- R9: In full-byte attribute mode (`cfg_half` = 0), bits 6:4 of the attribute are the colour for set bits and bits 2:0 are the colour for clear bits. `rgb` bit 2 is red, bit 1 green, bit 0 blue.
- R10: In half-rate mode (`cfg_half` = 1), attribute reads occur only for even columns. Bits 7:4 colour the even column and bits 3:0 the following odd column. Within a nibble, bits 3:2 give the foreground code and bits 1:0 the background code. The codes 0,1,2,3 map to 000, 100, 110, 111.
- R11: At scale code 0 (x1), `cfg_attr` has no effect: no attribute read is issued and the output is the plain monochrome stream.
- R12: The byte on `mem_data` is taken on the clock after the read request that asked for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_act | input | 1 | High for the 640-slot active window of a line |
| row_idx | input | 3 | Pixel row within the current character row |
| cfg_scale | input | 2 | Pixel hold: 0 = x1, 1 = x2, 2 = x3, 3 = x4 |
| cfg_attr | input | 1 | Enable colour attribute fetch and decode |
| cfg_half | input | 1 | One attribute byte per column pair |
| mem_rd | output | 1 | Memory read request this clock |
| mem_is_attr | output | 1 | Request is an attribute read (else bitmap) |
| mem_col | output | 7 | Character column of the request |
| mem_data | input | 8 | Read data, valid the clock after the request |
| rgb | output | 3 | Pixel colour, red in bit 2 |

## Verification
On a single clock edge, the bitmap for column k moves from the fetch register into the display register, and the byte for column k+1 lands in the fetch register. The same edge is also where the last pixel of one column gives way to the first pixel of the next. The bench returns a distinct byte for every column and compares every output slot of full lines at each scale, with attributes off, full and half-rate. Any slip at that edge therefore shows up as a pixel that belongs to the wrong column.

// File: rtl/attr_pixel_serializer.sv
module attr_pixel_serializer #(
  parameter int LINE_CYC  = 640,
  parameter int BUF_DEPTH = 40,
  parameter int COL_W     = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_act,
  input  logic [2:0]       row_idx,
  input  logic [1:0]       cfg_scale,
  input  logic             cfg_attr,
  input  logic             cfg_half,
  output logic             mem_rd,
  output logic             mem_is_attr,
  output logic [COL_W-1:0] mem_col,
  input  logic [7:0]       mem_data,
  output logic [2:0]       rgb
);
  localparam int NC1 = LINE_CYC / 8;
  localparam int NC2 = LINE_CYC / 16;
  localparam int NC3 = LINE_CYC / 24;
  localparam int NC4 = LINE_CYC / 32;
  localparam int AIDX_W = $clog2(BUF_DEPTH);

  logic [1:0]       ph;
  logic [2:0]       bt;
  logic [COL_W-1:0] col;
  logic [COL_W-1:0] nfull;

  always_comb begin
    case (cfg_scale)
      2'd0:    nfull = COL_W'(NC1);
      2'd1:    nfull = COL_W'(NC2);
      2'd2:    nfull = COL_W'(NC3);
      default: nfull = COL_W'(NC4);
    endcase
  end

  wire attr_on = cfg_attr && (cfg_scale != 2'd0);
  wire [COL_W-1:0] nfetch = attr_on ? nfull - 1'b1 : nfull;
  wire in_range = col < nfetch;
  wire pstart   = (ph == 2'd0) && (bt == 3'd0);
  wire bmp_req  = line_act && pstart && in_range;
  wire atr_req  = line_act && attr_on && (row_idx == 3'd0) && (ph == 2'd0) &&
                  (bt == 3'd4) && in_range && (!cfg_half || !col[0]);

  assign mem_rd      = bmp_req | atr_req;
  assign mem_is_attr = atr_req;
  assign mem_col     = col;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= '0; bt <= '0; col <= '0;
    end else if (!line_act) begin
      ph <= '0; bt <= '0; col <= '0;
    end else if (ph == cfg_scale) begin
      ph <= '0;
      if (bt == 3'd7) begin
        bt <= '0;
        if (col != '1) col <= col + 1'b1;
      end else begin
        bt <= bt + 1'b1;
      end
    end else begin
      ph <= ph + 1'b1;
    end
  end

  logic             pend_b, pend_a;
  logic [COL_W-1:0] pend_col;
  logic [7:0]       fetched, held;
  logic [7:0]       abuf [BUF_DEPTH];
  logic             d1_act, d1_ps, d2_act;
  logic [2:0]       d1_bt, d2_bt;
  logic [COL_W-1:0] d1_col, d2_col;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_b <= 1'b0; pend_a <= 1'b0; pend_col <= '0;
      fetched <= '0; held <= '0;
      d1_act <= 1'b0; d1_ps <= 1'b0; d1_bt <= '0; d1_col <= '0;
      d2_act <= 1'b0; d2_bt <= '0; d2_col <= '0;
      for (int i = 0; i < BUF_DEPTH; i++) abuf[i] <= '0;
    end else begin
      pend_b   <= bmp_req;
      pend_a   <= atr_req;
      pend_col <= col;
      if (pend_b) fetched <= mem_data;
      if (pend_a && pend_col < COL_W'(BUF_DEPTH)) abuf[pend_col[AIDX_W-1:0]] <= mem_data;
      d1_act <= line_act; d1_ps <= pstart; d1_bt <= bt; d1_col <= col;
      if (d1_act && d1_ps) held <= fetched;
      d2_act <= d1_act; d2_bt <= d1_bt; d2_col <= d1_col;
    end
  end

  function automatic logic [2:0] cmap(input logic [1:0] c);
    case (c)
      2'd0:    cmap = 3'b000;
      2'd1:    cmap = 3'b100;
      2'd2:    cmap = 3'b110;
      default: cmap = 3'b111;
    endcase
  endfunction

  wire [COL_W-1:0] dcol = attr_on ? d2_col - 1'b1 : d2_col;
  wire lead = attr_on && (d2_col == '0);
  wire vis  = d2_act && !lead && (dcol < nfetch);
  wire [7:0] bmap = attr_on ? held : fetched;
  wire pix = bmap[3'd7 - d2_bt];
  wire [COL_W-1:0] aidx = cfg_half ? {dcol[COL_W-1:1], 1'b0} : dcol;
  wire [7:0] abyte = (aidx < COL_W'(BUF_DEPTH)) ? abuf[aidx[AIDX_W-1:0]] : 8'h00;
  wire [3:0] nib = dcol[0] ? abyte[3:0] : abyte[7:4];
  wire [2:0] fg = cfg_half ? cmap(nib[3:2]) : abyte[6:4];
  wire [2:0] bg = cfg_half ? cmap(nib[1:0]) : abyte[2:0];
  wire [2:0] colour = !attr_on ? {3{pix}} : (pix ? fg : bg);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rgb <= '0;
    else        rgb <= vis ? colour : 3'b000;
  end

  logic [COL_W-1:0] last_bcol;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_bcol <= '0;
    else if (mem_rd && !mem_is_attr) last_bcol <= mem_col;
  end

  AST_BMP_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mem_rd && !mem_is_attr) |-> !mem_rd); // R2
  AST_ATTR_AFTER_BMP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && mem_is_attr) |-> (mem_col == last_bcol)); // R6
  AST_BLACK_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(line_act, 3) |-> (rgb == 3'b000)); // R5
  AST_X1_NO_ATTR: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_scale == 2'd0) |-> !(mem_rd && mem_is_attr)); // R11
endmodule

// File: tb/sim_attr_pixel_serializer.sv
`timescale 1ns/1ps
module sim_attr_pixel_serializer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line_act = 1'b0;
  logic [2:0] row_idx = '0;
  logic [1:0] cfg_scale = '0;
  logic       cfg_attr = 1'b0;
  logic       cfg_half = 1'b0;
  logic       mem_rd, mem_is_attr;
  logic [6:0] mem_col;
  logic [7:0] mem_data = '0;
  logic [2:0] rgb;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;
  int bseed = 0;
  int aseed = 0;
  int aseed_row0 = 0;

  always #10 clk = ~clk;

  attr_pixel_serializer u0 (
    .clk(clk), .rst_n(rst_n), .line_act(line_act), .row_idx(row_idx),
    .cfg_scale(cfg_scale), .cfg_attr(cfg_attr), .cfg_half(cfg_half),
    .mem_rd(mem_rd), .mem_is_attr(mem_is_attr), .mem_col(mem_col),
    .mem_data(mem_data), .rgb(rgb)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] bmpf(input int k);
    return 8'((k * 29 + bseed * 7) ^ 8'h3C);
  endfunction

  function automatic logic [7:0] attrf(input int seed, input int k);
    return 8'(k * 71 + seed);
  endfunction

  function automatic logic [2:0] cm(input logic [1:0] c);
    case (c)
      2'd0: return 3'b000;
      2'd1: return 3'b100;
      2'd2: return 3'b110;
      default: return 3'b111;
    endcase
  endfunction

  function automatic logic [2:0] exp_pix(input int s, input int sc, input bit at, input bit hf);
    int S, P, col, bitn, F, dcol;
    bit aon;
    logic [7:0] b, a;
    logic [3:0] nb;
    logic p;
    S = sc + 1; P = 8 * S;
    if (s < 0 || s >= 640) return 3'b000;
    aon = at && (sc != 0);
    F = 640 / P - (aon ? 1 : 0);
    col = s / P;
    bitn = (s % P) / S;
    if (aon && col == 0) return 3'b000;
    dcol = aon ? col - 1 : col;
    if (dcol >= F) return 3'b000;
    b = bmpf(dcol);
    p = b[7 - bitn];
    if (!aon) return p ? 3'b111 : 3'b000;
    if (!hf) begin
      a = attrf(aseed_row0, dcol);
      return p ? a[6:4] : a[2:0];
    end
    a = attrf(aseed_row0, dcol & ~1);
    nb = (dcol % 2 == 1) ? a[3:0] : a[7:4];
    return p ? cm(nb[3:2]) : cm(nb[1:0]);
  endfunction

  task automatic run_line(input int sc, input bit at, input bit hf, input int row,
                          input string ptag);
    int S, P, F, na_exp;
    int bad_pix, bad_win, bad_req, nb, na;
    bit aon;
    logic [7:0] resp;
    logic [2:0] e;
    S = sc + 1; P = 8 * S;
    aon = at && (sc != 0);
    F = 640 / P - (aon ? 1 : 0);
    na_exp = (aon && row == 0) ? (hf ? (F + 1) / 2 : F) : 0;
    bad_pix = 0; bad_win = 0; bad_req = 0; nb = 0; na = 0;
    resp = 8'h5A;
    if (row == 0) aseed_row0 = aseed;
    for (int i = 0; i < 644; i++) begin
      @(negedge clk);
      cfg_scale = 2'(sc); cfg_attr = at; cfg_half = hf; row_idx = 3'(row);
      line_act = (i < 640);
      mem_data = resp;
      resp = 8'h5A;
      #1;
      if (mem_rd) begin
        if (mem_is_attr) begin
          na++;
          if (!(aon && row == 0 && i == int'(mem_col) * P + 4 * S &&
                (!hf || mem_col[0] == 1'b0))) bad_req++;
          resp = attrf(aseed, int'(mem_col));
        end else begin
          nb++;
          if (i != int'(mem_col) * P) bad_req++;
          resp = bmpf(int'(mem_col));
        end
      end
      e = exp_pix(i - 3, sc, at, hf);
      if (rgb !== e) bad_pix++;
      if ((i < 3 || i >= 643) && rgb !== 3'b000) bad_win++;
    end
    check(bad_pix == 0, ptag, bad_pix, 0);
    check(bad_win == 0, "R5 window", bad_win, 0);
    check(nb == F && bad_req == 0, "R2 bitmap reads", nb, F);
    if (na_exp > 0) check(na == na_exp && bad_req == 0, "R6 attribute reads", na, na_exp);
    else if (aon) check(na == 0, "R7 no attribute read off row 0", na, 0);
    else check(na == 0, "R11 no attribute read", na, 0);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check(rgb == 3'b000 && mem_rd == 1'b0, "R1 during reset", int'(rgb), 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(rgb == 3'b000 && mem_rd == 1'b0, "R1 after reset", int'(rgb), 0);
  endtask

  task automatic t_plain;
    bseed = 1; run_line(0, 1'b0, 1'b0, 3, "R3 R12 x1 pixels");
    bseed = 2; run_line(1, 1'b0, 1'b0, 0, "R3 x2 pixels");
    bseed = 3; run_line(3, 1'b0, 1'b0, 5, "R3 x4 pixels");
    bseed = 4; run_line(2, 1'b0, 1'b0, 1, "R4 x3 pixels");
  endtask

  task automatic t_x1_attr_ignored;
    bseed = 5; aseed = 9; run_line(0, 1'b1, 1'b0, 0, "R11 x1 with attr set");
  endtask

  task automatic t_full_attr;
    bseed = 6; aseed = 17; run_line(1, 1'b1, 1'b0, 0, "R8 R9 x2 full attr row 0");
    bseed = 7; aseed = 99; run_line(1, 1'b1, 1'b0, 5, "R7 R9 x2 buffered attr");
    bseed = 8; aseed = 33; run_line(2, 1'b1, 1'b0, 0, "R4 R8 x3 full attr");
  endtask

  task automatic t_half_attr;
    bseed = 9;  aseed = 45;  run_line(3, 1'b1, 1'b1, 0, "R10 x4 half attr row 0");
    bseed = 10; aseed = 200; run_line(3, 1'b1, 1'b1, 2, "R7 R10 x4 half buffered");
    bseed = 11; aseed = 77;  run_line(1, 1'b1, 1'b1, 0, "R10 x2 half attr");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_plain();
    t_x1_attr_ignored();
    t_full_attr();
    t_half_attr();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule